// File: doc/BRIEF.md
# Real-to-Absolute Address Prefixing Unit

This unit turns a 64-bit real address into a 64-bit absolute address, so that each processor can keep its own 8 KiB low-storage save area somewhere other than address zero. It holds one prefix register per instance. A set-prefix write port loads that register, and a store-prefix read port returns its value.

Translation swaps two 8 KiB regions. A real address whose upper field (bits 0 to 50, with bit 0 the most significant) is all zero is redirected to the area the prefix names. A real address that falls inside the prefix area is redirected to page zero. Every other address passes through unchanged. The byte offset inside the 8 KiB area (bits 51 to 63) is never altered. Translations flow through one output register with a valid strobe.

Top module: `rtoa_prefix_unit`

## Requirements
- R1: After reset, the store-prefix read port returns zero and out_valid_o is low.
- R2: A set-prefix write stores only bits 33 to 50 of the written value (Verilog bits [30:13]). Bits 0 to 32 ([63:31]) and 51 to 63 ([12:0]) always read back as zero.
- R3: When real-address bits [63:13] are all zero, the output bits [63:13] equal prefix bits [63:13].
- R4: When real-address bits [63:13] equal nonzero prefix bits [63:13], the output bits [63:13] are zero.
- R5: A real address that lies in neither the zero area nor the prefix area appears at the output unchanged.
- R6: Output bits [12:0] always equal real-address bits [12:0].
- R7: With a zero prefix, the output equals the input for every address.
- R8: A translation accepted in the same cycle as a prefix write uses the old prefix. A translation accepted on the following cycle uses the new prefix.
- R9: out_valid_o follows in_valid_i one cycle later, and abs_addr_o shows the result in that cycle. While no translation is accepted, abs_addr_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfx_we_i | input | 1 | Set-prefix write strobe |
| pfx_wdata_i | input | 64 | Value to load into the prefix register |
| pfx_rdata_o | output | 64 | Current prefix value (store-prefix read) |
| in_valid_i | input | 1 | Real address valid |
| real_addr_i | input | 64 | Real address |
| out_valid_o | output | 1 | Absolute address valid |
| abs_addr_o | output | 64 | Absolute address |

## Verification
A corrupted prefix register shows up as a non-zero bit outside [30:13] on the read port. It also shows up, one cycle later, as a wrong upper field on the next translation of page zero or of the prefix area. A broken area comparison shows up only when those areas are hit, so the stimulus deliberately aims addresses at both areas, at their neighbours, and at a zero prefix. A write-timing error appears on the single translation issued in the write cycle, which is why that back-to-back case is driven directly.

// File: rtl/rtoa_prefix_pkg.sv
package rtoa_prefix_pkg;
  parameter int unsigned ADDR_W  = 64;
  parameter int unsigned AREA_W  = 13;  // 8 KiB area offset bits
  parameter int unsigned PFX_TOP = 31;  // prefix bits at or above this read as zero

  localparam int unsigned HI_W = ADDR_W - AREA_W;

  typedef logic [ADDR_W-1:0] addr_t;

  function automatic addr_t keep_mask();
    addr_t m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i >= AREA_W) && (i < PFX_TOP);
    return m;
  endfunction
endpackage

// File: rtl/rtoa_prefix_reg.sv
module rtoa_prefix_reg
  import rtoa_prefix_pkg::*;
#(
  parameter bit STORE_PORT = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  addr_t wdata_i,
  output addr_t pfx_o,
  output addr_t rdata_o
);
  localparam addr_t KEEP = keep_mask();

  addr_t pfx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pfx_q <= '0;
    else if (we_i) pfx_q <= wdata_i & KEEP;
  end

  assign pfx_o = pfx_q;

  generate
    if (STORE_PORT) begin : g_store
      assign rdata_o = pfx_q;
    end else begin : g_no_store
      assign rdata_o = '0;
    end
  endgenerate
endmodule

// File: rtl/rtoa_prefix_xlate.sv
module rtoa_prefix_xlate
  import rtoa_prefix_pkg::*;
(
  input  addr_t real_i,
  input  addr_t pfx_i,
  output addr_t abs_o
);
  logic [HI_W-1:0] real_hi, pfx_hi, abs_hi;

  assign real_hi = real_i[ADDR_W-1:AREA_W];
  assign pfx_hi  = pfx_i[ADDR_W-1:AREA_W];

  // zero-area test first: a zero prefix then maps 0 -> 0 with no conflict
  always_comb begin
    if (real_hi == '0)         abs_hi = pfx_hi;
    else if (real_hi == pfx_hi) abs_hi = '0;
    else                        abs_hi = real_hi;
  end

  assign abs_o = {abs_hi, real_i[AREA_W-1:0]};
endmodule

// File: rtl/rtoa_prefix_unit.sv
module rtoa_prefix_unit
  import rtoa_prefix_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pfx_we_i,
  input  logic [63:0] pfx_wdata_i,
  output logic [63:0] pfx_rdata_o,
  input  logic        in_valid_i,
  input  logic [63:0] real_addr_i,
  output logic        out_valid_o,
  output logic [63:0] abs_addr_o
);
  addr_t pfx, abs_d, abs_q;
  logic  vld_q;

  rtoa_prefix_reg #(.STORE_PORT(1'b1)) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pfx_we_i),
    .wdata_i (pfx_wdata_i),
    .pfx_o   (pfx),
    .rdata_o (pfx_rdata_o)
  );

  rtoa_prefix_xlate i_xlate (
    .real_i (real_addr_i),
    .pfx_i  (pfx),
    .abs_o  (abs_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      abs_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) abs_q <= abs_d;
    end
  end

  assign out_valid_o = vld_q;
  assign abs_addr_o  = abs_q;
endmodule

// File: rtl/rtoa_prefix_chk.sv
module rtoa_prefix_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pfx_we_i,
  input logic [63:0] pfx_wdata_i,
  input logic [63:0] pfx_rdata_o,
  input logic        in_valid_i,
  input logic [63:0] real_addr_i,
  input logic        out_valid_o,
  input logic [63:0] abs_addr_o
);
  // R2
  pfx_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfx_we_i |=> pfx_rdata_o == {33'd0, $past(pfx_wdata_i[30:13]), 13'd0});

  // R9
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && $stable(abs_addr_o));

  // R6
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> abs_addr_o[12:0] == $past(real_addr_i[12:0]));

  // R3
  zero_area_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && real_addr_i[63:13] == '0 |=> abs_addr_o[63:13] == $past(pfx_rdata_o[63:13]));

  // R4
  pfx_area_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && real_addr_i[63:13] == pfx_rdata_o[63:13] && pfx_rdata_o[63:13] != '0
      |=> abs_addr_o[63:13] == '0);

  // R7
  identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pfx_rdata_o == '0 |=> abs_addr_o == $past(real_addr_i));
endmodule

bind rtoa_prefix_unit rtoa_prefix_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pfx_we_i    (pfx_we_i),
  .pfx_wdata_i (pfx_wdata_i),
  .pfx_rdata_o (pfx_rdata_o),
  .in_valid_i  (in_valid_i),
  .real_addr_i (real_addr_i),
  .out_valid_o (out_valid_o),
  .abs_addr_o  (abs_addr_o)
);

// File: tb/test_rtoa_prefix_unit.sv
module test_rtoa_prefix_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_we = 1'b0;
  logic [63:0] pfx_wdata = '0;
  logic [63:0] pfx_rdata;
  logic        in_valid = 1'b0;
  logic [63:0] real_addr = '0;
  logic        out_valid;
  logic [63:0] abs_addr;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [63:0] ref_pfx = '0;

  always #2 clk = ~clk;  // 250 MHz

  rtoa_prefix_unit i_rtoa_prefix_unit (
    .clk_i(clk), .rst_ni(rst_n), .pfx_we_i(pfx_we), .pfx_wdata_i(pfx_wdata),
    .pfx_rdata_o(pfx_rdata), .in_valid_i(in_valid), .real_addr_i(real_addr),
    .out_valid_o(out_valid), .abs_addr_o(abs_addr)
  );

  function automatic logic [63:0] exp_abs(logic [63:0] a, logic [63:0] p);
    logic [50:0] h;
    h = a[63:13];
    if (h == '0)              h = p[63:13];
    else if (h == p[63:13])   h = '0;
    return {h, a[12:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_pfx(logic [63:0] v);
    pfx_we = 1'b1; pfx_wdata = v;
    @(negedge clk);
    pfx_we = 1'b0;
    ref_pfx = {33'd0, v[30:13], 13'd0};
    check("R2", pfx_rdata, ref_pfx);
  endtask

  task automatic xlate(string req, logic [63:0] a);
    in_valid = 1'b1; real_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, abs_addr, exp_abs(a, ref_pfx));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", pfx_rdata, 64'd0);
    check("R1", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: zero prefix gives identity
    xlate("R7", 64'h0000_0000_0000_0123);
    xlate("R7", 64'h0000_0000_0000_3abc);
    xlate("R7", rnd64());

    // R2: all-ones write keeps only [30:13]
    set_pfx('1);
    set_pfx(64'h0000_0000_0004_6000);

    // R3 / R4 / R5 / R6
    xlate("R3", 64'h0000_0000_0000_1fff);
    xlate("R4", 64'h0000_0000_0004_6010);
    xlate("R5", 64'h0000_0000_0004_8010);
    xlate("R5", 64'h0000_0000_0000_2000);
    xlate("R5", 64'h8000_0000_0004_6000);
    xlate("R6", 64'hffff_ffff_ffff_ffff);

    // R9: idle cycle, output held
    held = abs_addr;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", abs_addr, held);

    // R8: write and translate in the same cycle
    pfx_we = 1'b1; pfx_wdata = 64'h0000_0000_1234_4000;
    in_valid = 1'b1; real_addr = 64'h0000_0000_0000_0040;
    @(negedge clk);
    pfx_we = 1'b0;
    check("R8", abs_addr, exp_abs(64'h40, ref_pfx));
    ref_pfx = 64'h0000_0000_1234_4000 & 64'h0000_0000_7fff_e000;
    real_addr = 64'h0000_0000_0000_0080;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", abs_addr, exp_abs(64'h80, ref_pfx));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      int unsigned k;
      if ($urandom_range(9) == 0) set_pfx(rnd64());
      k = $urandom_range(3);
      a = rnd64();
      if (k == 0) a[63:13] = '0;
      else if (k == 1) a[63:13] = ref_pfx[63:13];
      xlate(k == 0 ? "R3" : (k == 1 ? (ref_pfx == 0 ? "R7" : "R4") : "R5"), a);
      if ($urandom_range(3) == 0) begin
        held = abs_addr;
        @(negedge clk);
        check("R9", {63'd0, out_valid}, 64'd0);
        check("R9", abs_addr, held);
      end
    end

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", pfx_rdata, 64'd0);
    check("R1", {63'd0, out_valid}, 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule